// File: doc/BRIEF.md
# Jump Target Instruction Cache

This block keeps a handful of instructions that are already in their final, decompressed form, each filed under the uncompressed address it was fetched from. The fetch unit queries it only when the program counter is redirected by a taken jump or branch. On a hit, the stored instruction is handed straight to decode. That skips address translation, the instruction cache and the decompressor, which would otherwise leave three stages of bubbles behind the redirect. On a miss, the fetch goes down the normal path. When the decompressor later produces the target instruction, the fetch unit writes it into this block.

The store is fully associative. Each entry holds a valid bit, the full target address as its tag, and one instruction word. A new target goes into the lowest-numbered empty entry. Once every entry is in use, victims are chosen in round-robin order. A fill to an address that is already stored rewrites that entry in place. A flush input empties the whole store at once.

The lookup is combinational, so hit, miss and the instruction are answered in the same cycle as the redirect. Fills and flushes take effect at the next clock edge.

Top module: `jump_target_cache`

## Requirements
- R1: While reset (rst_n low, active low) is held and after it is released, every entry is empty, so every lookup reports a miss.
- R2: hit and miss are both 0 in any cycle where redir_valid is 0.
- R3: In a cycle where redir_valid is 1, exactly one of hit and miss is 1, answered in that same cycle from the stored contents.
- R4: On a hit, hit_instr carries the instruction stored for redir_addr. Whenever hit is 0, hit_instr is all zeros.
- R5: A fill (fill_valid 1) to an address not in the store writes the lowest-numbered empty entry. The address hits from the next cycle on.
- R6: When every entry is in use, a fill to a new address replaces the entry at a round-robin pointer. The pointer is 0 after reset and steps by one (wrapping after ENTRIES-1) after each such replacement. So with 8 entries, the 9th distinct fill evicts the 1st address and the 10th evicts the 2nd.
- R7: A fill to an address already stored rewrites that entry's instruction in place. It neither uses a new entry, evicts anything nor moves the pointer, and the address never matches more than one entry.
- R8: A lookup and a fill of the same address in the same cycle: the lookup is answered from the contents before the clock edge, and the fill follows R5 to R7.
- R9: flush empties every entry and returns the round-robin pointer to 0 at the next edge. A fill presented in the same cycle as flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the whole store at the next edge |
| redir_valid | input | 1 | Program counter redirected this cycle; perform a lookup |
| redir_addr | input | ADDR_W | Uncompressed target address to look up |
| hit | output | 1 | Target found; hit_instr is valid |
| miss | output | 1 | Target absent; use the normal fetch path |
| hit_instr | output | INSTR_W | Stored decompressed instruction, zero when no hit |
| fill_valid | input | 1 | Decompressed target instruction is being written |
| fill_addr | input | ADDR_W | Uncompressed address of the instruction being written |
| fill_instr | input | INSTR_W | Decompressed instruction to store |

## Verification
The assertions check on every cycle that a lookup without a redirect stays silent, that hit and miss are exclusive, and that the output word is zero when there is no hit. They also check that a fill is visible to the next lookup of its address, that a flush leaves nothing to hit, and that no address ever matches two entries. Which entry a new target lands in, the order of round-robin eviction, the pointer reset by flush, and in-place rewriting can only be seen through the bench's scenarios. Those scenarios fill past capacity and then probe which addresses still hit, comparing each answer with a reference model of the store.

// File: rtl/jump_target_cache.sv
module jump_target_cache #(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 64,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               redir_valid,
  input  logic [ADDR_W-1:0]  redir_addr,
  output logic               hit,
  output logic               miss,
  output logic [INSTR_W-1:0] hit_instr,
  input  logic               fill_valid,
  input  logic [ADDR_W-1:0]  fill_addr,
  input  logic [INSTR_W-1:0] fill_instr
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [ADDR_W-1:0]  tag_q  [ENTRIES];
  logic [INSTR_W-1:0] data_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] look_match;
  logic [ENTRIES-1:0] fill_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign look_match[i] = vld[i] && (tag_q[i] == redir_addr);
    assign fill_match[i] = vld[i] && (tag_q[i] == fill_addr);
  end

  assign hit  = redir_valid && (|look_match);
  assign miss = redir_valid && !(|look_match);

  always_comb begin
    hit_instr = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (look_match[i] && redir_valid) hit_instr = hit_instr | data_q[i];
  end

  logic [IDX_W-1:0] free_idx, same_idx, wr_idx;
  logic             any_free, any_same, replace;

  always_comb begin
    free_idx = '0;
    same_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i])       free_idx = IDX_W'(i);
      if (fill_match[i]) same_idx = IDX_W'(i);
    end
  end

  assign any_free = !(&vld);
  assign any_same = |fill_match;
  assign replace  = !any_same && !any_free;
  assign wr_idx   = any_same ? same_idx : (any_free ? free_idx : rr_q);

  wire do_fill = fill_valid && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld  <= '0;
      rr_q <= '0;
    end else if (fill_valid) begin
      vld[wr_idx] <= 1'b1;
      if (replace) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[wr_idx]  <= fill_addr;
      data_q[wr_idx] <= fill_instr;
    end
  end

endmodule

// File: rtl/jump_target_cache_chk.sv
module jump_target_cache_chk #(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 64,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               redir_valid,
  input logic [ADDR_W-1:0]  redir_addr,
  input logic               hit,
  input logic               miss,
  input logic [INSTR_W-1:0] hit_instr,
  input logic               fill_valid,
  input logic [ADDR_W-1:0]  fill_addr,
  input logic [INSTR_W-1:0] fill_instr,
  input logic [ENTRIES-1:0] look_match
);

  a_r2_silent_without_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |-> (!hit && !miss));

  a_r3_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (hit != miss));

  a_r4_quiet_word: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_instr == '0));

  a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=>
      ((redir_valid && redir_addr == $past(fill_addr)) -> (hit && hit_instr == $past(fill_instr))));

  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(look_match) <= 1);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);

endmodule

bind jump_target_cache jump_target_cache_chk #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .redir_valid(redir_valid),
  .redir_addr(redir_addr), .hit(hit), .miss(miss), .hit_instr(hit_instr),
  .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_instr(fill_instr),
  .look_match(look_match)
);

// File: tb/jump_target_cache_test.sv
`timescale 1ns/1ps
module jump_target_cache_test;
  localparam int AW = 32;
  localparam int IW = 64;
  localparam int N  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          redir_valid = 1'b0;
  logic [AW-1:0] redir_addr = '0;
  logic          hit, miss;
  logic [IW-1:0] hit_instr;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [IW-1:0] fill_instr = '0;

  always #2 clk = ~clk;

  jump_target_cache #(.ADDR_W(AW), .INSTR_W(IW), .ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .hit(hit), .miss(miss), .hit_instr(hit_instr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_instr(fill_instr)
  );

  int vectors = 0;
  int errors  = 0;

  bit          m_vld  [N];
  logic [AW-1:0] m_tag [N];
  logic [IW-1:0] m_data [N];
  int          m_rr;

  function automatic void model_clear();
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    m_rr = 0;
  endfunction

  function automatic int model_find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic void model_fill(logic [AW-1:0] a, logic [IW-1:0] d);
    int k;
    k = model_find(a);
    if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) k = i;
    if (k < 0) begin
      k = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_vld[k] = 1'b1; m_tag[k] = a; m_data[k] = d;
  endfunction

  task automatic check(string req, logic [IW-1:0] act, logic [IW-1:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit fl, bit rv, logic [AW-1:0] ra,
                      bit fv, logic [AW-1:0] fa, logic [IW-1:0] fi);
    int k;
    flush = fl; redir_valid = rv; redir_addr = ra;
    fill_valid = fv; fill_addr = fa; fill_instr = fi;
    #1;
    k = rv ? model_find(ra) : -1;
    check(req, IW'(hit),  IW'(k >= 0), "hit");
    check(req, IW'(miss), IW'(rv && k < 0), "miss");
    check(req, hit_instr, (k >= 0) ? m_data[k] : '0, "hit_instr");
    if (rst_n) begin
      if (fl) model_clear();
      else if (fv) model_fill(fa, fi);
    end
    @(negedge clk);
  endtask

  task automatic look(string req, logic [AW-1:0] a);
    step(req, 0, 1, a, 0, '0, '0);
  endtask

  task automatic put(string req, logic [AW-1:0] a, logic [IW-1:0] d);
    step(req, 0, 0, '0, 1, a, d);
  endtask

  function automatic logic [AW-1:0] ad(int i);
    return 32'h0000_4000 + AW'(i) * 32'h10;
  endfunction

  function automatic logic [IW-1:0] dv(int i);
    return {32'hABCD_0000 + 32'(i), 32'h1234_0000 ^ 32'(i * 7)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    model_clear();
    @(negedge clk);
    // R1: lookups during reset miss, fill during reset ignored
    step("R1", 0, 1, ad(1), 1, ad(1), dv(1));
    step("R1", 0, 1, ad(1), 0, '0, '0);
    rst_n = 1'b1;
    look("R1", ad(1));
    // R2: no redirect, silent even when present
    put("R5", ad(1), dv(1));
    step("R2", 0, 0, ad(1), 0, '0, '0);
    look("R3", ad(1));
    look("R4", ad(2));
    // R5/R6: fill to capacity then evict in round-robin order
    step("R9", 1, 0, '0, 0, '0, '0);
    for (int i = 0; i < N; i++) put("R5", ad(i), dv(i));
    for (int i = 0; i < N; i++) look("R5", ad(i));
    // R7: rewrite in place, no eviction
    put("R7", ad(3), dv(99));
    look("R7", ad(3));
    for (int i = 0; i < N; i++) look("R7", ad(i));
    put("R6", ad(20), dv(20));
    look("R6", ad(0));
    look("R6", ad(1));
    put("R6", ad(21), dv(21));
    look("R6", ad(1));
    look("R6", ad(2));
    // R8: same-cycle lookup and fill of an absent address
    step("R8", 0, 1, ad(30), 1, ad(30), dv(30));
    look("R8", ad(30));
    // R8: same-cycle lookup and fill of a present address
    step("R8", 0, 1, ad(30), 1, ad(30), dv(31));
    look("R8", ad(30));
    // R9: flush beats fill, pointer returns to 0
    step("R9", 1, 1, ad(30), 1, ad(40), dv(40));
    look("R9", ad(40));
    look("R9", ad(30));
    for (int i = 0; i < N; i++) put("R9", ad(50 + i), dv(50 + i));
    put("R9", ad(70), dv(70));
    look("R9", ad(50));
    look("R9", ad(51));
    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit fl, rv, fv;
      logic [AW-1:0] ra, fa;
      fl = ($urandom % 64) == 0;
      rv = ($urandom % 3) != 0;
      fv = ($urandom % 2) == 0;
      ra = ad($urandom % 14);
      fa = ($urandom % 4 == 0) ? ra : ad($urandom % 14);
      step("R3", fl, rv, ra, fv, fa, {$urandom, $urandom});
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule